// File: doc/BRIEF.md
# Configurable Pseudo-Random Test Pattern Generator

This block is a linear feedback shift register that produces pseudo-random stimulus for a circuit under test during built-in self-test. It stands in for stored deterministic patterns and keeps the area small: one register of flip-flops and a few XOR gates produce a long run of distinct patterns. The `MODULAR` parameter selects the structure. With `MODULAR = 0`, the block uses the external-XOR form: the parity of the tapped stages is shifted into stage 0. With `MODULAR = 1`, it uses the internal-XOR form: the last stage's output is folded into selected stage-to-stage links.

The characteristic polynomial arrives at run time on `polyIn`, and software or a test controller loads a starting state through `seedLoad`/`seedIn`. Because the feedback is pure XOR, an all-zero state would never leave zero. A zero seed is therefore replaced by the value 1, and the replacement is reported through a one-cycle pulse and a sticky flag. A counter reports how many patterns have been issued since the last load. A pulse marks the moment the state returns to the loaded seed, which is the end of one period.

Top module: `bist_lfsr_gen`

## Requirements
- R1: With `MODULAR = 0`, each enabled step produces next[i] = state[i-1] for i ≥ 1, and next[0] is the XOR of all state[i] whose `polyIn[i]` is 1.
- R2: With `MODULAR = 1`, each enabled step uses the feedback bit f = state[W-1] & `polyIn[W-1]`. It produces next[0] = f, and next[i] = state[i-1] ^ (`polyIn[i-1]` & f) for i ≥ 1.
- R3: With W = 3, a primitive polynomial (`3'b110` for the external form, `3'b101` for the internal form) and seed 1, seven steps visit seven distinct nonzero patterns and then return to the seed.
- R4: A load with `seedIn` equal to 0 places the value 1 in the register, and that value also becomes the seed for period detection.
- R5: `zeroSeedPulse` is high for exactly the cycle after each zero-seed load and is low otherwise.
- R6: `zeroSeedSticky` rises with the first zero-seed load and stays high until reset.
- R7: `patternCount` becomes 0 after a load and increments by one, modulo 2^CNT_W, on every enabled step.
- R8: `periodDone` is high in the cycle after a step whose new state equals the stored seed, and is low otherwise.
- R9: `seedLoad` takes priority over `enable`. While both are low, `pattern` and `patternCount` hold their values.
- R10: After reset, `pattern` is 1, `patternCount` is 0, and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seedLoad | input | 1 | Load `seedIn` as the new state and seed |
| seedIn | input | WIDTH | Seed value |
| polyIn | input | WIDTH | Feedback coefficients; bit i is the coefficient of stage i |
| enable | input | 1 | Advance one state |
| pattern | output | WIDTH | Current test pattern |
| patternCount | output | CNT_W | Patterns issued since the last load |
| zeroSeedPulse | output | 1 | One-cycle flag for a replaced zero seed |
| zeroSeedSticky | output | 1 | Sticky record of any zero seed since reset |
| periodDone | output | 1 | State returned to the seed on the last step |

## Verification
The bench builds two instances with WIDTH = 3: one with the external-XOR form and one with the internal-XOR form. Both share the same seed, load and enable stimulus. At three bits, a full period of seven states is short enough to check completely, including the return-to-seed pulse. Setting CNT_W = 4 brings the counter's wrap into reach after sixteen steps, and random polynomials exercise non-primitive feedback as well.

// File: rtl/bist_lfsr_pkg.sv
package bist_lfsr_pkg;
  typedef struct packed {
    logic loadSeed;
    logic useDefault;
    logic step;
  } lfsr_strobe_t;
endpackage

// File: rtl/lfsr_datapath.sv
module lfsr_datapath
  import bist_lfsr_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit MODULAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lfsr_strobe_t     strobe,
  input  logic [WIDTH-1:0] seedIn,
  input  logic [WIDTH-1:0] polyIn,
  output logic [WIDTH-1:0] pattern,
  output logic             nextHitsSeed
);
  localparam logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(1);

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] seedQ;
  logic [WIDTH-1:0] nextState;
  logic [WIDTH-1:0] loadVal;

  generate
    if (MODULAR) begin : gInternalXor
      logic fb;
      assign fb = stateQ[WIDTH-1] & polyIn[WIDTH-1];
      always_comb begin
        nextState[0] = fb;
        for (int i = 1; i < WIDTH; i++) begin
          nextState[i] = stateQ[i-1] ^ (polyIn[i-1] & fb);
        end
      end
    end else begin : gExternalXor
      logic fb;
      assign fb = ^(stateQ & polyIn);
      assign nextState = {stateQ[WIDTH-2:0], fb};
    end
  endgenerate

  assign loadVal = strobe.useDefault ? DEFAULT_SEED : seedIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= DEFAULT_SEED;
      seedQ  <= DEFAULT_SEED;
    end else if (strobe.loadSeed) begin
      stateQ <= loadVal;
      seedQ  <= loadVal;
    end else if (strobe.step) begin
      stateQ <= nextState;
    end
  end

  assign pattern      = stateQ;
  assign nextHitsSeed = (nextState == seedQ);
endmodule

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import bist_lfsr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seedLoad,
  input  logic             seedIsZero,
  input  logic             enable,
  input  logic             nextHitsSeed,
  output lfsr_strobe_t     strobe,
  output logic [CNT_W-1:0] patternCount,
  output logic             zeroSeedPulse,
  output logic             zeroSeedSticky,
  output logic             periodDone
);
  always_comb begin
    strobe.loadSeed   = seedLoad;
    strobe.useDefault = seedLoad & seedIsZero;
    strobe.step       = enable & ~seedLoad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      patternCount   <= '0;
      zeroSeedPulse  <= 1'b0;
      zeroSeedSticky <= 1'b0;
      periodDone     <= 1'b0;
    end else begin
      zeroSeedPulse  <= strobe.useDefault;
      zeroSeedSticky <= zeroSeedSticky | strobe.useDefault;
      periodDone     <= strobe.step & nextHitsSeed;
      if (strobe.loadSeed) begin
        patternCount <= '0;
      end else if (strobe.step) begin
        patternCount <= patternCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bist_lfsr_gen.sv
module bist_lfsr_gen
  import bist_lfsr_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit MODULAR = 1'b0,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedIn,
  input  logic [WIDTH-1:0] polyIn,
  input  logic             enable,
  output logic [WIDTH-1:0] pattern,
  output logic [CNT_W-1:0] patternCount,
  output logic             zeroSeedPulse,
  output logic             zeroSeedSticky,
  output logic             periodDone
);
  lfsr_strobe_t strobe;
  logic         nextHitsSeed;

  lfsr_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedIsZero(seedIn == '0),
    .enable(enable), .nextHitsSeed(nextHitsSeed), .strobe(strobe),
    .patternCount(patternCount), .zeroSeedPulse(zeroSeedPulse),
    .zeroSeedSticky(zeroSeedSticky), .periodDone(periodDone)
  );

  lfsr_datapath #(.WIDTH(WIDTH), .MODULAR(MODULAR)) uPath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .seedIn(seedIn),
    .polyIn(polyIn), .pattern(pattern), .nextHitsSeed(nextHitsSeed)
  );
endmodule

// File: rtl/bist_lfsr_gen_checker.sv
module bist_lfsr_gen_checker #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seedLoad,
  input logic [WIDTH-1:0] seedIn,
  input logic             enable,
  input logic [WIDTH-1:0] pattern,
  input logic [CNT_W-1:0] patternCount,
  input logic             zeroSeedPulse,
  input logic             zeroSeedSticky
);
  AST_ZERO_SEED_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (seedLoad && seedIn == '0) |=> (pattern == WIDTH'(1) && zeroSeedPulse)); // R4
  AST_PULSE_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(seedLoad && seedIn == '0) |=> !zeroSeedPulse); // R5
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    zeroSeedSticky |=> zeroSeedSticky); // R6
  AST_LOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    seedLoad |=> patternCount == '0); // R7
  AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!seedLoad && enable) |=> patternCount == CNT_W'($past(patternCount) + 1'b1)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!seedLoad && !enable) |=> ($stable(pattern) && $stable(patternCount))); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (seedLoad && seedIn != '0) |=> pattern == $past(seedIn)); // R9
endmodule

bind bist_lfsr_gen bist_lfsr_gen_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedIn(seedIn), .enable(enable),
  .pattern(pattern), .patternCount(patternCount), .zeroSeedPulse(zeroSeedPulse),
  .zeroSeedSticky(zeroSeedSticky)
);

// File: tb/tb_bist_lfsr_gen.sv
`timescale 1ns/1ps
module tb_bist_lfsr_gen;
  localparam int W = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seedLoad = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] seedIn = '0;
  logic [W-1:0] polyStd = 3'b110;
  logic [W-1:0] polyMod = 3'b101;

  logic [W-1:0] patStd, patMod;
  logic [CW-1:0] cntStd, cntMod;
  logic pulseStd, pulseMod, stickyStd, stickyMod, perStd, perMod;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bist_lfsr_gen #(.WIDTH(W), .MODULAR(1'b0), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedIn(seedIn), .polyIn(polyStd),
    .enable(enable), .pattern(patStd), .patternCount(cntStd), .zeroSeedPulse(pulseStd),
    .zeroSeedSticky(stickyStd), .periodDone(perStd));

  bist_lfsr_gen #(.WIDTH(W), .MODULAR(1'b1), .CNT_W(CW)) dutMod (
    .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedIn(seedIn), .polyIn(polyMod),
    .enable(enable), .pattern(patMod), .patternCount(cntMod), .zeroSeedPulse(pulseMod),
    .zeroSeedSticky(stickyMod), .periodDone(perMod));

  // Behavioural reference model
  int mStd, mMod, mSeed, mCount;
  bit mPulse, mSticky, mPerStd, mPerMod;

  function automatic int stepExternal(int s, int p);
    int fb = 0;
    for (int i = 0; i < W; i++) if (((p >> i) & 1) == 1) fb ^= (s >> i) & 1;
    return ((s << 1) | fb) % (1 << W);
  endfunction

  function automatic int stepInternal(int s, int p);
    int fb = ((s >> (W - 1)) & 1) & ((p >> (W - 1)) & 1);
    int r = fb;
    for (int i = 1; i < W; i++) begin
      int b = ((s >> (i - 1)) & 1) ^ (((p >> (i - 1)) & 1) & fb);
      r |= b << i;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mStd = 1; mMod = 1; mSeed = 1; mCount = 0;
      mPulse = 0; mSticky = 0; mPerStd = 0; mPerMod = 0;
    end else begin
      mPulse = 0; mPerStd = 0; mPerMod = 0;
      if (seedLoad) begin
        mSeed = (seedIn == 0) ? 1 : int'(seedIn);
        if (seedIn == 0) begin mPulse = 1; mSticky = 1; end
        mStd = mSeed; mMod = mSeed; mCount = 0;
      end else if (enable) begin
        mStd = stepExternal(mStd, int'(polyStd));
        mMod = stepInternal(mMod, int'(polyMod));
        mCount = (mCount + 1) % (1 << CW);
        mPerStd = (mStd == mSeed);
        mPerMod = (mMod == mSeed);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  bit compareOn = 1'b0;
  always @(negedge clk) begin
    if (compareOn) begin
      check("R1 external pattern", int'(patStd), mStd);
      check("R2 internal pattern", int'(patMod), mMod);
      check("R7 count", int'(cntStd), mCount);
      check("R7 count internal", int'(cntMod), mCount);
      check("R5 zero-seed pulse", int'(pulseStd), int'(mPulse));
      check("R5 zero-seed pulse internal", int'(pulseMod), int'(mPulse));
      check("R6 sticky", int'(stickyStd), int'(mSticky));
      check("R8 period external", int'(perStd), int'(mPerStd));
      check("R8 period internal", int'(perMod), int'(mPerMod));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seenStd[$];
    int seenMod[$];
    repeat (2) tick();
    // R10 reset values
    check("R10 reset pattern", int'(patStd), 1);
    check("R10 reset count", int'(cntStd), 0);
    check("R10 reset flags", int'({pulseStd, stickyStd, perStd}), 0);
    rst_n = 1'b1;
    compareOn = 1'b1;
    tick();
    // R3 full period from seed 1
    seedLoad = 1'b1; seedIn = 3'd1; tick();
    seedLoad = 1'b0; enable = 1'b1;
    for (int k = 0; k < 7; k++) begin
      tick();
      seenStd.push_back(int'(patStd));
      seenMod.push_back(int'(patMod));
    end
    begin
      int distStd = 0, distMod = 0;
      for (int a = 0; a < 7; a++) begin
        bit dupS = 0, dupM = 0;
        for (int b = 0; b < a; b++) begin
          if (seenStd[a] == seenStd[b]) dupS = 1;
          if (seenMod[a] == seenMod[b]) dupM = 1;
        end
        if (!dupS && seenStd[a] != 0) distStd++;
        if (!dupM && seenMod[a] != 0) distMod++;
      end
      check("R3 distinct external", distStd, 7);
      check("R3 distinct internal", distMod, 7);
      check("R3 back to seed", int'(patStd), 1);
      check("R8 period pulse at return", int'(perStd), 1);
    end
    // R7 counter wrap
    repeat (20) tick();
    // R9 hold while idle
    enable = 1'b0;
    repeat (3) tick();
    // R9 load wins over enable
    enable = 1'b1; seedLoad = 1'b1; seedIn = 3'd5; tick();
    check("R9 load priority", int'(patStd), 5);
    seedLoad = 1'b0;
    repeat (4) tick();
    // R4 zero seed replaced by 1
    seedLoad = 1'b1; seedIn = 3'd0; tick();
    check("R4 zero seed default", int'(patStd), 1);
    check("R5 pulse after zero load", int'(pulseStd), 1);
    seedLoad = 1'b0; tick();
    check("R5 pulse single cycle", int'(pulseStd), 0);
    check("R6 sticky kept", int'(stickyStd), 1);
    repeat (6) tick();
    // Random stimulus with arbitrary polynomials
    for (int k = 0; k < 400; k++) begin
      seedLoad = ($urandom % 10) == 0;
      seedIn = W'($urandom);
      enable = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) begin
        polyStd = W'($urandom); polyMod = W'($urandom);
      end
      tick();
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule